// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block is a byte-wide shift register that a processor uses to run a three-wire synchronous serial link. The link has one data-in pin, one data-out pin and one clock pin. The unit has no bit-rate generator of its own. In master operation, software moves the serial clock forward one edge at a time by writing a toggle strobe. In slave operation, the clock comes from another device. That external clock is synchronized into the system clock domain, and its edges drive the same shifting and counting logic.

Two edge modes select which clock edge samples the data-in pin and which edge updates the data-out pin. A 4-bit counter advances on every serial clock edge, so a byte completes after sixteen edges. When the counter wraps, a sticky flag is set, and that flag can raise an interrupt request. Host registers sit at three addresses. Address 0 is the data register, address 1 is control and address 2 is status.

A two-state machine tracks the serial clock level. Its states are LVL_LOW and LVL_HIGH. The RISE transition goes from LVL_LOW to LVL_HIGH. It fires on a toggle strobe in master operation, or when the synchronized external clock reads high in slave operation. The FALL transition goes from LVL_HIGH to LVL_LOW and fires on a toggle strobe or when the synchronized clock reads low. With no event, each state holds. Each transition produces a one-cycle edge event. That event moves the clock pin, drives the counter, and drives either the data sampling or the data-out update, depending on the edge mode.

Top module: `tws_unit`

## Requirements
- R1: After reset, sck_out, ser_do and irq are 0, and all three registers (data at address 0, control at address 1, status at address 2) read 0x00.
- R2: A host write to address 0 loads the data register, which reads back on host_rdata. From the following cycle, ser_do equals bit 7 of the written value.
- R3: Edge mode 0 is control bit 0 = 0. In this mode a rising serial clock edge shifts ser_di into data bit 0 and moves the register left, while ser_do does not change. A falling edge copies data bit 7 to ser_do.
- R4: Edge mode 1 is control bit 0 = 1. In this mode a rising edge copies data bit 7 to ser_do and leaves the register unchanged. A falling edge shifts ser_di into data bit 0.
- R5: Bits move most significant first. After eight full clock periods, the data register holds the eight sampled ser_di values, with the first value sampled in bit 7.
- R6: In master operation (control bit 1 = 0), each write of 1 to control bit 4 inverts sck_out exactly once, so one bit period takes two strobes. Bit 4 always reads 0.
- R7: The edge count sits in status bits 3:0. It increments on every rising and falling serial edge. A host write to address 2 loads it from wdata[3:0], and that load takes precedence over an edge in the same cycle.
- R8: An edge that finds the count at 15 wraps it to 0 and sets the overflow flag (status bit 6). The flag stays set until it is cleared.
- R9: Writing address 2 with bit 6 = 1 clears the flag. Writing address 2 with bit 6 = 0 leaves the flag unchanged.
- R10: irq is 1 exactly when the flag is set and control bit 2 (interrupt enable) is 1.
- R11: A host load of the data register wins over a sampling edge in the same cycle. The register then holds the written value, and the counter still counts that edge.
- R12: In slave operation (control bit 1 = 1), sck_in passes through two synchronizing flops. A change on sck_in reaches the count on the third rising system clock edge after the change. In this mode toggle strobes are ignored and sck_out stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write enable for one cycle |
| host_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| ser_di | input | 1 | Serial data in |
| ser_do | output | 1 | Serial data out |
| sck_in | input | 1 | External serial clock, used in slave operation |
| sck_out | output | 1 | Serial clock driven in master operation |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the unit with its default parameters: 8 data bits, a 4-bit edge counter and two synchronizer stages. These values make a whole byte transfer short enough to run in both edge modes and in both clock-source modes. The synchronizer latency, a counter wrap, the flag clear rules and a host load that lands in the same cycle as an external sampling edge can all be checked against hand-computed values. A behavioural model compares the serial pins, the interrupt and the addressed register on every clock.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] REG_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] REG_STAT = 2'd2;
    localparam int CTL_MODE_BIT = 0;
    localparam int CTL_EXT_BIT  = 1;
    localparam int CTL_IE_BIT   = 2;
    localparam int CTL_TOG_BIT  = 4;
    localparam int STAT_FLAG_BIT = 6;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } sck_state_e;

    typedef struct packed {
        logic ie;
        logic ext_clk;
        logic mode;
    } ctrl_t;
endpackage

// File: rtl/tws_clk_fsm.sv
module tws_clk_fsm
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slave_mode,
    input  logic tog_stb,
    input  logic sck_ext,
    output logic rise_ev,
    output logic fall_ev,
    output logic lvl
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_lvl;
    sck_state_e             state_q, state_n;

    // Synchronizer chain for the external clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= sck_ext;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end

    assign ext_lvl = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_n;
    end

    // Transitions: RISE and FALL
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LVL_LOW:  if (slave_mode ? ext_lvl : tog_stb)  state_n = LVL_HIGH;
            LVL_HIGH: if (slave_mode ? !ext_lvl : tog_stb) state_n = LVL_LOW;
            default:  state_n = LVL_LOW;
        endcase
    end

    // Outputs
    always_comb begin
        rise_ev = (state_q == LVL_LOW)  && (state_n == LVL_HIGH);
        fall_ev = (state_q == LVL_HIGH) && (state_n == LVL_LOW);
        lvl     = (state_q == LVL_HIGH);
    end

    assert_master_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !tog_stb) |=> $stable(state_q));

    assert_slave_no_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && (ext_lvl == lvl)) |=> $stable(state_q));
endmodule

// File: rtl/tws_shift_reg.sv
module tws_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              sample_ev,
    input  logic              change_ev,
    input  logic              di,
    output logic [DATA_W-1:0] data_q,
    output logic              dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= load_val;
        end else if (sample_ev) begin
            data_q <= {data_q[DATA_W-2:0], di};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (load) begin
            dout <= load_val[DATA_W-1];
        end else if (change_ev) begin
            dout <= data_q[DATA_W-1];
        end
    end

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> data_q == $past(load_val));

    assert_shift_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_ev && !load) |=> data_q == {$past(data_q[DATA_W-2:0]), $past(di)});

    assert_dout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !change_ev) |=> $stable(dout));
endmodule

// File: rtl/tws_edge_counter.sv
module tws_edge_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_ev,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wval,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wrap;
    assign wrap = edge_ev && !cnt_wr && (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_wr)   cnt_q <= cnt_wval;
        else if (edge_ev)  cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (flag_clr) ovf_q <= 1'b0;
        else if (wrap)     ovf_q <= 1'b1;
    end

    assert_edge_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev && !cnt_wr) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev && !cnt_wr && !flag_clr && cnt_q == CNT_MAX) |=> ovf_q);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !flag_clr) |=> ovf_q);
endmodule

// File: rtl/tws_unit.sv
module tws_unit
    import tws_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ser_di,
    output logic              ser_do,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic              wr_data, wr_ctrl, wr_stat, tog_stb;
    logic              rise_ev, fall_ev, lvl;
    logic              sample_ev, change_ev;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q;

    assign wr_data = host_wr && (host_addr == REG_DATA);
    assign wr_ctrl = host_wr && (host_addr == REG_CTRL);
    assign wr_stat = host_wr && (host_addr == REG_STAT);
    assign tog_stb = wr_ctrl && host_wdata[CTL_TOG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.mode    <= host_wdata[CTL_MODE_BIT];
            ctrl_q.ext_clk <= host_wdata[CTL_EXT_BIT];
            ctrl_q.ie      <= host_wdata[CTL_IE_BIT];
        end
    end

    tws_clk_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (ctrl_q.ext_clk),
        .tog_stb    (tog_stb),
        .sck_ext    (sck_in),
        .rise_ev    (rise_ev),
        .fall_ev    (fall_ev),
        .lvl        (lvl)
    );

    assign sample_ev = ctrl_q.mode ? fall_ev : rise_ev;
    assign change_ev = ctrl_q.mode ? rise_ev : fall_ev;

    tws_shift_reg #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_data),
        .load_val  (host_wdata),
        .sample_ev (sample_ev),
        .change_ev (change_ev),
        .di        (ser_di),
        .data_q    (data_q),
        .dout      (ser_do)
    );

    tws_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_ev  (rise_ev || fall_ev),
        .cnt_wr   (wr_stat),
        .cnt_wval (host_wdata[CNT_W-1:0]),
        .flag_clr (wr_stat && host_wdata[STAT_FLAG_BIT]),
        .cnt_q    (cnt_q),
        .ovf_q    (ovf_q)
    );

    assign sck_out = lvl && !ctrl_q.ext_clk;
    assign irq     = ovf_q && ctrl_q.ie;

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            REG_DATA: host_rdata = data_q;
            REG_CTRL: begin
                host_rdata[CTL_MODE_BIT] = ctrl_q.mode;
                host_rdata[CTL_EXT_BIT]  = ctrl_q.ext_clk;
                host_rdata[CTL_IE_BIT]   = ctrl_q.ie;
            end
            REG_STAT: begin
                host_rdata[CNT_W-1:0]    = cnt_q;
                host_rdata[STAT_FLAG_BIT] = ovf_q;
            end
            default: host_rdata = '0;
        endcase
    end

    assert_slave_clk_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.ext_clk |-> !sck_out);
endmodule

// File: tb/tws_unit_tb.sv
`timescale 1ns/1ps
module tws_unit_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       host_wr = 0;
    logic [1:0] host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       ser_di = 0;
    logic       ser_do;
    logic       sck_in = 0;
    logic       sck_out;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    tws_unit u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ser_di(ser_di),
        .ser_do(ser_do), .sck_in(sck_in), .sck_out(sck_out), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [7:0] m_data = 0;
    logic       m_do = 0, m_flag = 0, m_mode = 0, m_ext = 0, m_ie = 0, m_lvl = 0;
    int         m_cnt = 0;
    logic       m_sq[$] = '{1'b0, 1'b0};
    logic       m_run = 0;

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_data;
            2'd1: return {5'b0, m_ie, m_ext, m_mode};
            2'd2: return {1'b0, m_flag, 2'b0, 4'(m_cnt)};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_data = 0; m_do = 0; m_flag = 0; m_mode = 0; m_ext = 0; m_ie = 0;
            m_lvl = 0; m_cnt = 0; m_sq = '{1'b0, 1'b0};
        end else begin
            logic ext_old, tog, rise, fall, samp, chg, wd, wc, ws;
            logic [7:0] old_data;
            ext_old = m_sq[0];
            void'(m_sq.pop_front());
            m_sq.push_back(sck_in);
            wd = host_wr && host_addr == 2'd0;
            wc = host_wr && host_addr == 2'd1;
            ws = host_wr && host_addr == 2'd2;
            tog  = m_ext ? (ext_old != m_lvl) : (wc && host_wdata[4]);
            rise = tog && !m_lvl;
            fall = tog && m_lvl;
            samp = m_mode ? fall : rise;
            chg  = m_mode ? rise : fall;
            old_data = m_data;
            if (wd) m_data = host_wdata;
            else if (samp) m_data = {m_data[6:0], ser_di};
            if (wd) m_do = host_wdata[7];
            else if (chg) m_do = old_data[7];
            if (ws && host_wdata[6]) m_flag = 0;
            else if (!ws && tog && m_cnt == 15) m_flag = 1;
            if (ws) m_cnt = host_wdata[3:0];
            else if (tog) m_cnt = (m_cnt + 1) % 16;
            if (wc) begin m_mode = host_wdata[0]; m_ext = host_wdata[1]; m_ie = host_wdata[2]; end
            if (tog) m_lvl = !m_lvl;
            #2;
            if (m_run) begin
                check("R6 model sck_out", sck_out, m_lvl && !m_ext);
                check("R3/R4 model ser_do", ser_do, m_do);
                check("R10 model irq", irq, m_flag && m_ie);
                check("R2 model rdata", host_rdata, m_read(host_addr));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic strobe(input logic [7:0] ctl);
        wr(2'd1, ctl | 8'h10);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic master_byte(input logic [7:0] ctl, input logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            ser_di = rx[i];
            strobe(ctl);
            strobe(ctl);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        m_run = 1;
        idle(1);
        // R1 reset state
        check("R1 sck_out", sck_out, 0);
        check("R1 ser_do", ser_do, 0);
        check("R1 irq", irq, 0);
        rd(2'd0, rv); check("R1 data", rv, 8'h00);
        rd(2'd1, rv); check("R1 ctrl", rv, 8'h00);
        rd(2'd2, rv); check("R1 status", rv, 8'h00);

        // R2 load drives data-out
        wr(2'd0, 8'hA5);
        check("R2 ser_do msb", ser_do, 1);
        rd(2'd0, rv); check("R2 readback", rv, 8'hA5);
        wr(2'd0, 8'h5A);
        check("R2 ser_do msb zero", ser_do, 0);

        // Mode 0 master transfer with interrupt enable
        wr(2'd1, 8'h04);
        wr(2'd0, 8'hA5);
        ser_di = 0;
        strobe(8'h04);
        check("R6 sck rise", sck_out, 1);
        check("R3 do held on rise", ser_do, 1);
        rd(2'd2, rv); check("R7 count one", rv, 8'h01);
        rd(2'd0, rv); check("R3 sampled on rise", rv, 8'h4A);
        rd(2'd1, rv); check("R6 strobe reads 0", rv, 8'h04);
        strobe(8'h04);
        check("R6 sck fall", sck_out, 0);
        check("R3 do on fall", ser_do, 0);
        // remaining 7 bits of 0x3C pattern after first bit 0
        for (int i = 6; i >= 0; i--) begin
            ser_di = 8'h3C >> i;
            strobe(8'h04);
            if (i == 0) begin
                rd(2'd2, rv); check("R8 no flag at 15", rv, 8'h0F);
            end
            strobe(8'h04);
        end
        rd(2'd0, rv); check("R5 received byte", rv, 8'h3C);
        rd(2'd2, rv); check("R8 wrap flag", rv, 8'h40);
        check("R10 irq set", irq, 1);

        // R9 flag clearing
        wr(2'd2, 8'h03);
        rd(2'd2, rv); check("R9 zero write keeps flag", rv, 8'h43);
        wr(2'd1, 8'h00);
        check("R10 irq masked", irq, 0);
        wr(2'd1, 8'h04);
        check("R10 irq re-enabled", irq, 1);
        wr(2'd2, 8'h40);
        rd(2'd2, rv); check("R9 one clears", rv, 8'h00);
        check("R10 irq clear", irq, 0);

        // Mode 1 master transfer
        wr(2'd1, 8'h01);
        wr(2'd0, 8'hC3);
        ser_di = 1;
        strobe(8'h01);
        rd(2'd0, rv); check("R4 no sample on rise", rv, 8'hC3);
        check("R4 do after rise", ser_do, 1);
        strobe(8'h01);
        rd(2'd0, rv); check("R4 sample on fall", rv, 8'h87);
        ser_di = 0;
        strobe(8'h01);
        strobe(8'h01);
        check("R4 do b6", ser_do, 1);
        strobe(8'h01);
        check("R4 do b5 on rise", ser_do, 0);
        strobe(8'h01);
        for (int i = 4; i >= 0; i--) begin
            ser_di = 8'h96 >> i;
            strobe(8'h01);
            strobe(8'h01);
        end
        rd(2'd0, rv); check("R5 mode1 byte", rv, 8'h96);
        rd(2'd2, rv); check("R8 mode1 flag", rv, 8'h40);

        // R7 count load then wrap
        wr(2'd2, 8'h4E);
        rd(2'd2, rv); check("R7 count load", rv, 8'h0E);
        strobe(8'h01);
        strobe(8'h01);
        rd(2'd2, rv); check("R8 wrap after load", rv, 8'h40);
        wr(2'd2, 8'h40);

        // R12 slave mode
        wr(2'd1, 8'h02);
        strobe(8'h02);
        check("R12 sck_out low", sck_out, 0);
        rd(2'd2, rv); check("R12 strobe ignored", rv, 8'h00);
        sck_in = 1;
        idle(1);
        rd(2'd2, rv); check("R12 sync stage 1", rv, 8'h00);
        idle(1);
        rd(2'd2, rv); check("R12 sync stage 2", rv, 8'h00);
        idle(1);
        rd(2'd2, rv); check("R12 third edge", rv, 8'h01);
        sck_in = 0;
        idle(4);
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h00);
        for (int i = 7; i >= 0; i--) begin
            ser_di = 8'h5B >> i;
            sck_in = 1; idle(4);
            sck_in = 0; idle(4);
        end
        rd(2'd0, rv); check("R12 slave byte", rv, 8'h5B);
        rd(2'd2, rv); check("R12 slave wrap", rv, 8'h40);

        // R11 load against coincident sampling edge
        ser_di = 1;
        sck_in = 1;
        idle(1);
        wr(2'd0, 8'h81);
        rd(2'd0, rv); check("R11 load wins", rv, 8'h81);
        rd(2'd2, rv); check("R11 edge still counted", rv, 8'h41);
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule